// File: doc/BRIEF.md
# Three-Phase CCD Clock Sequencer

This block drives the logical levels of the three gate phases of a three-phase charge-coupled shift register. A pixel transfer is a loop of six steps, named A to F. In each step either two neighbouring wells are high, so that charge spreads across them, or a single well is high, so that the charge is pushed into it. After a full loop the packet sits one pixel further along. Only high and low levels are produced. Analog drive, slew and device-specific waveform tuning happen outside the block.

A pulse on `start` loads a pixel count N and the direction of travel. The block then makes N full loops. It moves forward by one step only in a cycle where `step_en` is high, so the strobe rate sets how long each step lasts. Each return to step A raises a one-cycle `pix_done` pulse. The last return also raises `seq_done` and ends the run. While the block is idle, the phases rest in step A.

Top module: `ccd3_phase_seq`

## Requirements
- R1: While reset is held, and after it is released, the phases show step A ({ph1,ph2,ph3} = 3'b110), `busy` is low, and `pix_done` and `seq_done` are low.
- R2: Going forward, the phases {ph1,ph2,ph3} follow A=110, B=010, C=011, D=001, E=101, F=100 and then return to A.
- R3: Each step changes exactly one phase. The phases are never all low and never all high.
- R4: The step index advances only on a rising edge where `busy` and `step_en` are both high. When `step_en` is high while idle, the phases do not move.
- R5: If `reverse` is 1 at the start pulse, the run walks the steps in the order A, F, E, D, C, B, A. The value is held for the whole run.
- R6: A start pulse while idle, with a nonzero `pix_count`, raises `busy` on the next edge. `pix_done` is high for exactly the one cycle in which the phases first show step A again after a loop.
- R7: `seq_done` is high for one cycle, together with the Nth `pix_done`. `busy` is low in that same cycle.
- R8: A start pulse while `busy` is high is ignored. The count and direction of the run in progress are kept.
- R9: A start pulse with `pix_count` = 0 is ignored. `busy` stays low and the phases stay at step A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Strobe: advance one step in this cycle |
| start | input | 1 | Begin a run of `pix_count` pixel shifts |
| pix_count | input | CNT_W | Number of pixel shifts in the run |
| reverse | input | 1 | 1 = move charge the opposite way |
| ph1 | output | 1 | Phase 1 level |
| ph2 | output | 1 | Phase 2 level |
| ph3 | output | 1 | Phase 3 level |
| busy | output | 1 | A run is in progress |
| pix_done | output | 1 | One-cycle pulse on each return to step A |
| seq_done | output | 1 | One-cycle pulse when the last pixel finishes |

## Verification
Each result is due one clock edge after its cause:
- `busy` rises on the edge that samples `start`.
- The phases, `pix_done` and `seq_done` all change on the edge that samples `step_en`.

The bench drives its inputs on the falling edge and reads the outputs on the next falling edge, after exactly one rising edge has passed. It then compares them with a step index that it tracks itself. Idle gaps between strobes are checked cycle by cycle to confirm that nothing moves.

// File: rtl/ccd3_phase_seq.sv
module ccd3_phase_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             start,
  input  logic [CNT_W-1:0] pix_count,
  input  logic             reverse,
  output logic             ph1,
  output logic             ph2,
  output logic             ph3,
  output logic             busy,
  output logic             pix_done,
  output logic             seq_done
);
  localparam logic [2:0]       STEP_A = 3'd0;
  localparam logic [2:0]       STEP_F = 3'd5;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [2:0]       step_q;
  logic [CNT_W-1:0] left_q;
  logic             rev_q;

  wire       adv    = busy & step_en;
  wire [2:0] step_n = rev_q ? ((step_q == STEP_A) ? STEP_F : step_q - 3'd1)
                            : ((step_q == STEP_F) ? STEP_A : step_q + 3'd1);
  wire       wrap   = adv & (step_n == STEP_A);
  wire       last   = (left_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= STEP_A;
      left_q   <= '0;
      rev_q    <= 1'b0;
      busy     <= 1'b0;
      pix_done <= 1'b0;
      seq_done <= 1'b0;
    end else begin
      pix_done <= wrap;
      seq_done <= wrap & last;
      if (!busy && start && pix_count != '0) begin
        busy   <= 1'b1;
        left_q <= pix_count;
        rev_q  <= reverse;
      end else if (adv) begin
        step_q <= step_n;
        if (wrap) begin
          left_q <= left_q - ONE;
          if (last) busy <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (step_q)
      3'd1:    {ph1, ph2, ph3} = 3'b010;
      3'd2:    {ph1, ph2, ph3} = 3'b011;
      3'd3:    {ph1, ph2, ph3} = 3'b001;
      3'd4:    {ph1, ph2, ph3} = 3'b101;
      3'd5:    {ph1, ph2, ph3} = 3'b100;
      default: {ph1, ph2, ph3} = 3'b110;
    endcase
  end
endmodule

// File: rtl/ccd3_phase_seq_chk.sv
module ccd3_phase_seq_chk (
  input logic clk,
  input logic rst,
  input logic step_en,
  input logic ph1,
  input logic ph2,
  input logic ph3,
  input logic busy,
  input logic pix_done,
  input logic seq_done
);
  wire [2:0] ph = {ph1, ph2, ph3};

  a_r3_single_edge: assert property (@(posedge clk) disable iff (rst)
    $countones(ph ^ $past(ph)) <= 1);
  a_r3_not_flat: assert property (@(posedge clk) disable iff (rst)
    ph != 3'b000 && ph != 3'b111);
  a_r1_idle_rest: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ph == 3'b110);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(ph));
  a_r6_pulse_short: assert property (@(posedge clk) disable iff (rst)
    pix_done |=> !pix_done);
  a_r6_pulse_at_a: assert property (@(posedge clk) disable iff (rst)
    pix_done |-> ph == 3'b110);
  a_r7_done_pair: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> pix_done && !busy);
endmodule

bind ccd3_phase_seq ccd3_phase_seq_chk u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .ph1(ph1), .ph2(ph2), .ph3(ph3),
  .busy(busy), .pix_done(pix_done), .seq_done(seq_done)
);

// File: tb/ccd3_phase_seq_bench.sv
module ccd3_phase_seq_bench;
  localparam int CNT_W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] pix_count = '0;
  logic reverse = 1'b0;
  logic ph1, ph2, ph3, busy, pix_done, seq_done;
  int compared = 0;
  int mismatched = 0;
  int idx = 0;

  always #2.5 clk = ~clk;

  ccd3_phase_seq #(.CNT_W(CNT_W)) u_ccd3_phase_seq (
    .clk(clk), .rst(rst), .step_en(step_en), .start(start), .pix_count(pix_count),
    .reverse(reverse), .ph1(ph1), .ph2(ph2), .ph3(ph3), .busy(busy),
    .pix_done(pix_done), .seq_done(seq_done));

  function automatic logic [2:0] pat(int i);
    case (i)
      1: return 3'b010;
      2: return 3'b011;
      3: return 3'b001;
      4: return 3'b101;
      5: return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    chk("R1 phases in reset", {5'd0, ph1, ph2, ph3}, 8'h06);
    rst = 1'b0;
    tick();
    chk("R1 phases after reset", {5'd0, ph1, ph2, ph3}, 8'h06);
    chk("R1 outputs after reset", {5'd0, busy, pix_done, seq_done}, 8'h00);
    idx = 0;
  endtask

  task automatic t_run(int n, bit rev, int gap, bit poke);
    logic [2:0] prev;
    start = 1'b1; pix_count = CNT_W'(n); reverse = rev;
    tick();
    start = 1'b0; pix_count = '0; reverse = 1'b0;
    chk("R6 busy after start", {7'd0, busy}, 8'h01);
    for (int p = 0; p < n; p++) begin
      for (int s = 1; s <= 6; s++) begin
        if (poke && p == 0 && s == 3) begin
          start = 1'b1; pix_count = CNT_W'(n + 3); reverse = ~rev;
        end
        prev = {ph1, ph2, ph3};
        step_en = 1'b1;
        tick();
        step_en = 1'b0; start = 1'b0; pix_count = '0; reverse = 1'b0;
        idx = rev ? (idx + 5) % 6 : (idx + 1) % 6;
        chk(rev ? "R5 reverse pattern" : "R2 forward pattern",
            {5'd0, ph1, ph2, ph3}, {5'd0, pat(idx)});
        chk("R3 one phase per step",
            8'($countones(prev ^ {ph1, ph2, ph3})), 8'd1);
        chk("R6 pix_done", {7'd0, pix_done}, {7'd0, s == 6});
        chk("R7 seq_done", {7'd0, seq_done}, {7'd0, s == 6 && p == n - 1});
        chk("R7 busy", {7'd0, busy}, {7'd0, !(s == 6 && p == n - 1)});
        for (int g = 0; g < gap; g++) begin
          tick();
          chk("R4 hold without strobe", {5'd0, ph1, ph2, ph3}, {5'd0, pat(idx)});
          chk("R6 pulse one cycle", {6'd0, pix_done, seq_done}, 8'h00);
        end
      end
    end
    if (poke) chk("R8 start while busy ignored", {7'd0, busy}, 8'h00);
  endtask

  task automatic t_idle_strobe();
    start = 1'b1; pix_count = '0;
    tick();
    start = 1'b0;
    chk("R9 zero count ignored", {7'd0, busy}, 8'h00);
    for (int k = 0; k < 4; k++) begin
      step_en = 1'b1;
      tick();
      chk("R4 idle strobe no move", {5'd0, ph1, ph2, ph3}, 8'h06);
    end
    step_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_run(1, 1'b0, 0, 1'b0);
    t_run(3, 1'b0, 2, 1'b0);
    t_run(2, 1'b1, 1, 1'b0);
    t_run(2, 1'b0, 0, 1'b1);
    t_idle_strobe();
    t_run(1, 1'b1, 3, 1'b0);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule